// File: doc/BRIEF.md
# Contiguous Access Merge Buffer

This block gathers a run of small memory accesses into one larger transfer of at most `MAX_BYTES` bytes. Each piece is 1, 2, 4, 8 or 16 bytes long. A piece joins the buffer only if it starts at the byte where the buffered run ends and carries the same access kind and exclusive flag. Each new piece sits above the bytes already held, so the buffered word reads as one little-endian value that starts at the captured base address.

A flush command closes the run. A write flush returns the buffered bytes. A read flush returns the bytes from a memory read that arrive on `mem_rdata`. When big-endian mode is on, those read bytes are reversed over the merged length. The buffer is empty again in the cycle after a successful flush. Any push or flush that breaks the rules is refused with a one-cycle error pulse and does not change the buffer. All outputs are registered, so each result appears one clock after the cycle in which its command was presented.

Top module: `acc_merge_buf`

## Requirements
- R1: During and right after a synchronous reset, `out_valid`, `push_err` and `flush_err` are 0 and the buffer is empty.
- R2: A legal push into an empty buffer captures its address, kind (2 bits: 0 normal, 1 streaming, 2 unprivileged, 3 ordered), exclusive flag and `push_size` low bytes of `push_data`, with the bytes above them treated as zero.
- R3: A legal push into a non-empty buffer places its bytes starting at byte offset equal to the current count. The count then grows by `push_size`.
- R4: A push into a non-empty buffer is refused if its kind or exclusive flag differs from the captured one, or if its address differs from the base plus the count, taken modulo 2^ADDR_W. A refused push raises `push_err` one cycle later and leaves the buffer unchanged.
- R5: A push is refused in the same way if its size is not a power of two from 1 to `MAX_BYTES`, if the count would exceed `MAX_BYTES`, or if it is exclusive with kind 1 or 2.
- R6: A push presented in the same cycle as a flush is always refused with `push_err`, and the flush proceeds normally.
- R7: A successful write flush (`flush_rd`=0) pulses `out_valid` one cycle later. It returns the base address, the byte count, the kind, the exclusive flag and the buffered bytes in `out_data`, with zeros above the count. The buffer is empty in the next cycle.
- R8: A flush whose `flush_excl` differs from the captured exclusive flag is refused with `flush_err`. For a successful exclusive write flush, `out_ok` equals `mem_excl_ok`. For every other flush, `out_ok` is 0.
- R9: A read flush (`flush_rd`=1) succeeds only if `flush_size` equals the count, and it is otherwise refused with `flush_err` with the buffer unchanged. On success, `out_data` holds the low count bytes of `mem_rdata` and zeros above them.
- R10: On a read flush with `big_endian`=1, output byte i is `mem_rdata` byte (count-1-i) for each i below the count.
- R11: A flush on an empty buffer raises `flush_err` and gives no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push command |
| push_addr | input | ADDR_W | Byte address of the piece |
| push_size | input | SIZE_W | Piece length in bytes |
| push_kind | input | 2 | Access kind code |
| push_excl | input | 1 | Exclusive flag of the piece |
| push_data | input | DATA_W | Piece bytes, low bytes used |
| flush_valid | input | 1 | Flush command |
| flush_rd | input | 1 | 1 = read flush, 0 = write flush |
| flush_excl | input | 1 | Exclusive flavour of the flush |
| flush_size | input | SIZE_W | Expected byte count for a read flush |
| big_endian | input | 1 | Reverse read bytes |
| mem_rdata | input | DATA_W | Read data from memory for a read flush |
| mem_excl_ok | input | 1 | Exclusive write success from memory |
| out_valid | output | 1 | Merged access result valid |
| out_addr | output | ADDR_W | Merged base address |
| out_size | output | SIZE_W | Merged byte count |
| out_kind | output | 2 | Merged access kind |
| out_excl | output | 1 | Merged exclusive flag |
| out_ok | output | 1 | Exclusive write success |
| out_data | output | DATA_W | Merged data |
| push_err | output | 1 | Push refused (one-cycle pulse) |
| flush_err | output | 1 | Flush refused (one-cycle pulse) |

## Verification
Most wrong internal states stay hidden until the next command that depends on them. A stale or mis-added count shows up as a wrong `out_size`, or as a spurious `push_err` on the next contiguous push, one cycle after that push. Lanes that are written in the wrong place or not cleared show only in `out_data` at the next flush. A base address or exclusive flag that was not captured correctly shows as a contiguity error or a `flush_err` one cycle after the following command. For this reason the reference model is compared on every clock, and each scenario ends in a flush that makes the buffer contents visible.

// File: rtl/amb_pkg.sv
package amb_pkg;
  typedef enum logic [1:0] {
    KIND_NORMAL   = 2'd0,
    KIND_STREAM   = 2'd1,
    KIND_UNPRIV   = 2'd2,
    KIND_ORDERED  = 2'd3
  } acc_kind_e;

  // exclusive accesses are only meaningful for plain and ordered kinds
  function automatic logic kind_allows_excl(input acc_kind_e k);
    return (k == KIND_NORMAL) || (k == KIND_ORDERED);
  endfunction
endpackage

// File: rtl/amb_push_check.sv
module amb_push_check import amb_pkg::*; #(
  parameter int ADDR_W    = 64,
  parameter int MAX_BYTES = 16,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic [SIZE_W-1:0] cnt,
  input  logic [ADDR_W-1:0] base,
  input  acc_kind_e         kind,
  input  logic              excl,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [SIZE_W-1:0] p_size,
  input  acc_kind_e         p_kind,
  input  logic              p_excl,
  output logic              legal
);
  logic [SIZE_W:0] total;
  logic size_pow2, fits, excl_fine, same_attr, contiguous, is_empty;

  always_comb begin
    size_pow2  = (p_size != '0) && ((p_size & (p_size - 1'b1)) == '0)
                 && (int'(p_size) <= MAX_BYTES);
    total      = {1'b0, cnt} + {1'b0, p_size};
    fits       = int'(total) <= MAX_BYTES;
    excl_fine  = !p_excl || kind_allows_excl(p_kind);
    is_empty   = (cnt == '0);
    same_attr  = (p_kind == kind) && (p_excl == excl);
    contiguous = (p_addr == base + ADDR_W'(cnt));
    legal      = size_pow2 && fits && excl_fine
                 && (is_empty || (same_attr && contiguous));
  end
endmodule

// File: rtl/amb_lanes.sv
module amb_lanes #(
  parameter int MAX_BYTES = 16,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_off,
  input  logic [SIZE_W-1:0] wr_len,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] masked, shifted;

  always_comb begin
    masked = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (k < int'(wr_len)) masked[k*8 +: 8] = wr_data[k*8 +: 8];
    shifted = masked << {wr_off, 3'b000};
  end

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_lane
    logic hit;
    assign hit = wr_en && (j >= int'(wr_off)) && (j < int'(wr_off) + int'(wr_len));
    always_ff @(posedge clk) begin
      if (rst || clear) rd_data[j*8 +: 8] <= '0;
      else if (hit)     rd_data[j*8 +: 8] <= shifted[j*8 +: 8];
    end
  end
endmodule

// File: rtl/amb_swap.sv
module amb_swap #(
  parameter int MAX_BYTES = 16,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic [SIZE_W-1:0] nbytes,
  input  logic              reverse,
  output logic [DATA_W-1:0] out_data
);
  always_comb begin
    out_data = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      for (int j = 0; j < MAX_BYTES; j++) begin
        if (i < int'(nbytes)) begin
          if (reverse && (j == int'(nbytes) - 1 - i))
            out_data[i*8 +: 8] = in_data[j*8 +: 8];
          else if (!reverse && (j == i))
            out_data[i*8 +: 8] = in_data[j*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/acc_merge_buf.sv
module acc_merge_buf import amb_pkg::*; #(
  parameter int ADDR_W    = 64,
  parameter int MAX_BYTES = 16,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [SIZE_W-1:0] push_size,
  input  logic [1:0]        push_kind,
  input  logic              push_excl,
  input  logic [DATA_W-1:0] push_data,
  input  logic              flush_valid,
  input  logic              flush_rd,
  input  logic              flush_excl,
  input  logic [SIZE_W-1:0] flush_size,
  input  logic              big_endian,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_excl_ok,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [1:0]        out_kind,
  output logic              out_excl,
  output logic              out_ok,
  output logic [DATA_W-1:0] out_data,
  output logic              push_err,
  output logic              flush_err
);
  logic [SIZE_W-1:0] cnt_q;
  logic [ADDR_W-1:0] base_q;
  acc_kind_e         kind_q;
  logic              excl_q;
  logic [DATA_W-1:0] held_data, swap_src, swap_out;
  logic              push_legal, push_take, push_bad, flush_bad, flush_ok;

  amb_push_check #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_check (
    .cnt(cnt_q), .base(base_q), .kind(kind_q), .excl(excl_q),
    .p_addr(push_addr), .p_size(push_size), .p_kind(acc_kind_e'(push_kind)),
    .p_excl(push_excl), .legal(push_legal)
  );

  always_comb begin
    flush_bad = (cnt_q == '0) || (flush_excl != excl_q)
                || (flush_rd && (flush_size != cnt_q));
    flush_ok  = flush_valid && !flush_bad;
    push_take = push_valid && !flush_valid && push_legal;
    push_bad  = push_valid && (flush_valid || !push_legal);
    swap_src  = flush_rd ? mem_rdata : held_data;
  end

  amb_lanes #(.MAX_BYTES(MAX_BYTES)) u_lanes (
    .clk(clk), .rst(rst), .clear(flush_ok), .wr_en(push_take),
    .wr_off(cnt_q), .wr_len(push_size), .wr_data(push_data), .rd_data(held_data)
  );

  amb_swap #(.MAX_BYTES(MAX_BYTES)) u_swap (
    .in_data(swap_src), .nbytes(cnt_q), .reverse(flush_rd && big_endian),
    .out_data(swap_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      base_q <= '0;
      kind_q <= KIND_NORMAL;
      excl_q <= 1'b0;
    end else if (flush_ok) begin
      cnt_q  <= '0;
    end else if (push_take) begin
      if (cnt_q == '0) begin
        base_q <= push_addr;
        kind_q <= acc_kind_e'(push_kind);
        excl_q <= push_excl;
      end
      cnt_q <= cnt_q + push_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      push_err  <= 1'b0;
      flush_err <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
      out_kind  <= '0;
      out_excl  <= 1'b0;
      out_ok    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= flush_ok;
      push_err  <= push_bad;
      flush_err <= flush_valid && flush_bad;
      if (flush_ok) begin
        out_addr <= base_q;
        out_size <= cnt_q;
        out_kind <= kind_q;
        out_excl <= excl_q;
        out_ok   <= excl_q && !flush_rd && mem_excl_ok;
        out_data <= swap_out;
      end
    end
  end
endmodule

// File: rtl/amb_chk.sv
module amb_chk #(
  parameter int ADDR_W    = 64,
  parameter int MAX_BYTES = 16,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_valid,
  input logic [SIZE_W-1:0] push_size,
  input logic [1:0]        push_kind,
  input logic              push_excl,
  input logic              flush_valid,
  input logic              out_valid,
  input logic [SIZE_W-1:0] out_size,
  input logic              out_excl,
  input logic              out_ok,
  input logic              push_err,
  input logic              flush_err
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !push_err && !flush_err));

  // R6
  push_flush_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && flush_valid) |=> push_err);

  // R5
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && ((push_size == '0) || ((push_size & (push_size - 1'b1)) != '0)
     || (int'(push_size) > MAX_BYTES))) |=> push_err);

  // R5
  excl_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && push_excl && (push_kind == 2'd1 || push_kind == 2'd2)) |=> push_err);

  // R7
  out_size_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_size != '0) && (int'(out_size) <= MAX_BYTES)));

  // R7
  empty_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R11
  flush_excl_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && flush_err));

  // R8
  ok_needs_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_excl) |-> !out_ok);
endmodule

bind acc_merge_buf amb_chk #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_chk (.*);

// File: tb/acc_merge_buf_tb.sv
module acc_merge_buf_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 0, push_excl = 0, flush_valid = 0, flush_rd = 0;
  logic flush_excl = 0, big_endian = 0, mem_excl_ok = 0;
  logic [63:0] push_addr = '0;
  logic [4:0] push_size = '0, flush_size = '0;
  logic [1:0] push_kind = '0;
  logic [127:0] push_data = '0, mem_rdata = '0;
  logic out_valid, out_excl, out_ok, push_err, flush_err;
  logic [63:0] out_addr;
  logic [4:0] out_size;
  logic [1:0] out_kind;
  logic [127:0] out_data;

  always #2.5 clk = ~clk;

  acc_merge_buf u_dut (.*);

  int total = 0, bad = 0;
  string tag = "R1";
  logic [7:0] mq[$];
  logic [63:0] m_addr;
  logic [1:0] m_kind;
  logic m_excl;
  logic e_pe, e_fe, e_ov, e_ok, e_excl, chk_en = 0;
  logic [63:0] e_addr;
  logic [4:0] e_size;
  logic [1:0] e_kind;
  logic [127:0] e_data;

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    int n;
    bit ok;
    e_pe = 0; e_fe = 0; e_ov = 0;
    chk_en = 1;
    if (rst) mq.delete();
    else if (flush_valid) begin
      if (push_valid) e_pe = 1;
      n = mq.size();
      if (n == 0 || flush_excl != m_excl || (flush_rd && int'(flush_size) != n)) e_fe = 1;
      else begin
        e_ov = 1; e_addr = m_addr; e_size = 5'(n); e_kind = m_kind; e_excl = m_excl;
        e_ok = m_excl && !flush_rd && mem_excl_ok;
        e_data = '0;
        for (int k = 0; k < n; k++)
          if (!flush_rd) e_data[k*8 +: 8] = mq[k];
          else if (big_endian) e_data[k*8 +: 8] = mem_rdata[(n-1-k)*8 +: 8];
          else e_data[k*8 +: 8] = mem_rdata[k*8 +: 8];
        mq.delete();
      end
    end else if (push_valid) begin
      n = mq.size();
      ok = (push_size == 1 || push_size == 2 || push_size == 4 || push_size == 8 || push_size == 16);
      if (push_excl && (push_kind == 1 || push_kind == 2)) ok = 0;
      if (n + int'(push_size) > 16) ok = 0;
      if (n != 0 && (push_kind != m_kind || push_excl != m_excl || push_addr != m_addr + 64'(n))) ok = 0;
      if (!ok) e_pe = 1;
      else begin
        if (n == 0) begin m_addr = push_addr; m_kind = push_kind; m_excl = push_excl; end
        for (int k = 0; k < int'(push_size); k++) mq.push_back(push_data[k*8 +: 8]);
      end
    end
  end

  task automatic check(input bit good, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check(push_err == e_pe, "push_err", 128'(push_err), 128'(e_pe));
    check(flush_err == e_fe, "flush_err", 128'(flush_err), 128'(e_fe));
    check(out_valid == e_ov, "out_valid", 128'(out_valid), 128'(e_ov));
    if (e_ov && out_valid) begin
      check(out_addr == e_addr, "out_addr", 128'(out_addr), 128'(e_addr));
      check(out_size == e_size, "out_size", 128'(out_size), 128'(e_size));
      check(out_kind == e_kind, "out_kind", 128'(out_kind), 128'(e_kind));
      check(out_excl == e_excl, "out_excl", 128'(out_excl), 128'(e_excl));
      check(out_ok == e_ok, "out_ok", 128'(out_ok), 128'(e_ok));
      check(out_data == e_data, "out_data", out_data, e_data);
    end
  end

  task automatic push(input logic [63:0] a, input int s, input logic [1:0] k,
                      input logic x, input logic [127:0] d);
    push_valid = 1; push_addr = a; push_size = 5'(s); push_kind = k; push_excl = x; push_data = d;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic flush(input logic rd, input logic x, input int s, input logic be,
                       input logic [127:0] rdata, input logic okbit);
    flush_valid = 1; flush_rd = rd; flush_excl = x; flush_size = 5'(s);
    big_endian = be; mem_rdata = rdata; mem_excl_ok = okbit;
    @(negedge clk);
    flush_valid = 0;
  endtask

  task automatic wr_flush(); flush(0, 0, 0, 0, '0, 0); endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R11"; wr_flush();
    tag = "R2";  push(64'h1000, 4, 0, 0, 128'hFFFF_0000_AABB_CCDD); @(negedge clk);
    tag = "R7";  wr_flush(); @(negedge clk);
    tag = "R3";
    push(64'h2000, 1, 0, 0, 128'h11); push(64'h2001, 1, 0, 0, 128'h22);
    push(64'h2002, 2, 0, 0, 128'h4433); push(64'h2004, 4, 0, 0, 128'h8877_6655);
    push(64'h2008, 8, 0, 0, 128'hFFEE_DDCC_BBAA_9900);
    tag = "R7";  wr_flush(); wr_flush();
    tag = "R4";
    push(64'h3000, 2, 3, 0, 128'hBEEF); push(64'h3004, 2, 3, 0, 128'h1);
    push(64'h3002, 2, 0, 0, 128'h2); push(64'h3002, 2, 3, 1, 128'h3);
    push(64'h3002, 2, 3, 0, 128'hCAFE); wr_flush();
    push(64'hFFFF_FFFF_FFFF_FFFC, 4, 1, 0, 128'h0102_0304);
    push(64'h0, 4, 1, 0, 128'h0506_0708); wr_flush();
    tag = "R5";
    push(64'h4000, 3, 0, 0, 128'h1); push(64'h4000, 0, 0, 0, 128'h1);
    push(64'h4000, 4, 1, 1, 128'h1); push(64'h4000, 4, 2, 1, 128'h1);
    push(64'h4000, 16, 2, 0, {4{32'h1234_5678}}); push(64'h4010, 1, 2, 0, 128'h9);
    wr_flush();
    tag = "R6";
    push(64'h4100, 4, 0, 0, 128'hA5A5_A5A5);
    push_valid = 1; push_addr = 64'h4104; push_size = 4; push_data = 128'h5A5A;
    wr_flush(); wr_flush();
    tag = "R8";
    push(64'h5000, 8, 0, 1, 128'h0123_4567_89AB_CDEF);
    flush(0, 0, 0, 0, '0, 1); flush(0, 1, 0, 0, '0, 1);
    push(64'h5100, 4, 3, 1, 128'h7777); flush(0, 1, 0, 0, '0, 0);
    push(64'h5200, 4, 0, 0, 128'h1); flush(0, 0, 0, 0, '0, 1);
    tag = "R9";
    push(64'h6000, 4, 0, 0, '0); push(64'h6004, 4, 0, 0, '0);
    flush(1, 0, 4, 0, 128'h1, 0);
    flush(1, 0, 8, 0, 128'hDEAD_BEEF_0011_2233_4455_6677_8899_AABB, 0);
    tag = "R10";
    push(64'h7000, 4, 3, 0, '0); push(64'h7004, 4, 3, 0, '0);
    flush(1, 0, 8, 1, 128'hDEAD_BEEF_0011_2233_4455_6677_8899_AABB, 0);
    push(64'h7100, 2, 0, 0, '0); push(64'h7102, 1, 0, 0, '0);
    flush(1, 0, 3, 1, 128'h0000_0000_0000_0000_0000_0000_00C3_B2A1, 0);
    push(64'h7200, 16, 0, 1, '0);
    flush(1, 1, 16, 1, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule